// File: doc/BRIEF.md
# Dual-Mode Floating-Point Multiplier

This block multiplies floating-point numbers in one of two precision modes. A mode input chosen per operation decides whether the two 64-bit operand words hold one binary64 number each, or two binary32 numbers each. In the first case the block returns one binary64 product. In the second case it returns two binary32 products, one for each half-word, computed in the same cycle. The sign of a product is the XOR of the operand signs. Its exponent is the sum of the operand exponents less the format bias. The significand is the product of the operand significands with their hidden ones, normalised and rounded to nearest with ties to even.

The block is meant to be fed one operation per clock. Each operation carries a valid strobe that travels with it. An input register stage and an output register stage can each be turned on or off with a parameter. Subnormal operands are treated as zero, and results too small to be normal are flushed to zero. Each lane reports two flags: overflow and invalid operation.

Top module: `fpmul_dual`

## Requirements
- R1: With `i_op` = 1 the block returns the binary64 product of `i_a` and `i_b` on all 64 bits of `o_res`, and `o_ovf[1]` and `o_inv[1]` are 0. With `i_op` = 0 it returns the binary32 product of the upper halves (bits 63:32) in `o_res[63:32]` and the binary32 product of the lower halves (bits 31:0) in `o_res[31:0]`.
- R2: `o_valid` rises exactly IN_REG+OUT_REG cycles after an accepted `i_valid`, with one result per operation in issue order. `o_valid` is 0 while reset is held.
- R3: The result sign is the XOR of the operand signs. This includes zero and infinite results.
- R4: The result exponent is the sum of the operand exponents minus 127 (binary32) or 1023 (binary64). If the significand product is 2.0 or more, it is shifted right by one place and the exponent is raised by one.
- R5: The significand is rounded to nearest, ties to even. The decision uses the first dropped bit and a sticky OR of all lower dropped bits. A rounding carry raises the exponent.
- R6: An operand with a zero exponent field counts as zero, even if its fraction is nonzero. A result whose final biased exponent is 0 or less becomes a zero with the XOR sign.
- R7: A finite result whose biased exponent reaches the all-ones value becomes an infinity with the XOR sign, and the lane's overflow flag is set.
- R8: A NaN operand, or zero times infinity, gives the quiet NaN with sign 0: 0x7FC00000 in binary32, 0x7FF8000000000000 in binary64. The lane's invalid flag is set.
- R9: In binary32 mode neither lane's operands change the other lane's result or flags.
- R10: Infinity times a nonzero finite number, or times infinity, gives an infinity with the XOR sign and no flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| i_valid | input | 1 | Operation strobe |
| i_op | input | 1 | Mode: 1 = one binary64 product, 0 = two binary32 products |
| i_a | input | 64 | First operand word |
| i_b | input | 64 | Second operand word |
| o_valid | output | 1 | Result strobe |
| o_res | output | 64 | Product word |
| o_ovf | output | 2 | Overflow flag per lane; bit 1 upper lane, bit 0 lower lane or binary64 |
| o_inv | output | 2 | Invalid flag per lane; same bit order as o_ovf |

## Verification
In binary32 mode the two lanes finish in the same cycle. One lane can therefore hit a special case while the other does ordinary rounding: a NaN next to a tie-to-even, or an overflow next to a flush to zero. The bench builds a set of hand-checked binary32 cases and packs each one into both halves, paired with a different partner every time. Each half and each flag bit is then compared with the value that case gives on its own. Any bleed-through between the lanes therefore shows up as a failure on a specific lane.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int DW     = 64;
  localparam int HW     = DW / 2;
  localparam int FRAC_D = 52;
  localparam int FRAC_S = 23;
  localparam int EXP_D  = 11;
  localparam int EXP_S  = 8;
  localparam int SIGW   = FRAC_D + 1;
  localparam int PW     = 2 * SIGW;
  localparam int EXW    = EXP_D + 3;
  localparam int ALIGN  = FRAC_D - FRAC_S;
  localparam int BIAS_D = 1023;
  localparam int BIAS_S = 127;

  typedef enum logic {
    FPM_PAIR32 = 1'b0,
    FPM_ONE64  = 1'b1
  } fpm_op_e;
endpackage

// File: rtl/fpm_rst_sync.sv
module fpm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/fpm_lane.sv
module fpm_lane
  import fpm_pkg::*;
(
  input  logic          dbl,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] r,
  output logic          ovf,
  output logic          inv
);
  logic                sa, sb, sgn;
  logic [EXP_D-1:0]    ea, eb, emax;
  logic [FRAC_D-1:0]   fa, fb;
  logic                za, zb, ia, ib, na, nb;
  logic [SIGW-1:0]     siga, sigb;
  logic [PW-1:0]       prod;
  logic                hi, xs;
  logic [PW-2:0]       m;
  logic signed [EXW-1:0] bias, ex, exr;
  logic [SIGW-1:0]     kd;
  logic [SIGW:0]       rd;
  logic                gd, sd;
  logic [FRAC_S:0]     ks;
  logic [FRAC_S+1:0]   rs;
  logic                gs, ss, cy;
  logic                big, tiny;
  logic                s_out;
  logic [EXP_D-1:0]    e_out;
  logic [FRAC_D-1:0]   f_out;
  logic                unused_bits;

  // operand unpack: binary32 fraction is left-aligned into the wide field
  always_comb begin
    sa = dbl ? a[DW-1] : a[HW-1];
    sb = dbl ? b[DW-1] : b[HW-1];
    ea = dbl ? a[DW-2 -: EXP_D] : {{(EXP_D-EXP_S){1'b0}}, a[HW-2 -: EXP_S]};
    eb = dbl ? b[DW-2 -: EXP_D] : {{(EXP_D-EXP_S){1'b0}}, b[HW-2 -: EXP_S]};
    fa = dbl ? a[FRAC_D-1:0] : {a[FRAC_S-1:0], {ALIGN{1'b0}}};
    fb = dbl ? b[FRAC_D-1:0] : {b[FRAC_S-1:0], {ALIGN{1'b0}}};
    emax = dbl ? {EXP_D{1'b1}} : {{(EXP_D-EXP_S){1'b0}}, {EXP_S{1'b1}}};
    za = (ea == '0);
    zb = (eb == '0);
    ia = (ea == emax) && (fa == '0);
    ib = (eb == emax) && (fb == '0);
    na = (ea == emax) && (fa != '0);
    nb = (eb == emax) && (fb != '0);
    sgn = sa ^ sb;
  end

  // shared significand product and exponent sum
  always_comb begin
    siga = {1'b1, fa};
    sigb = {1'b1, fb};
    prod = PW'(siga) * PW'(sigb);
    hi   = prod[PW-1];
    m    = hi ? prod[PW-1:1] : prod[PW-2:0];
    xs   = hi & prod[0];
    bias = dbl ? EXW'(BIAS_D) : EXW'(BIAS_S);
    ex   = $signed({3'b000, ea}) + $signed({3'b000, eb}) - bias
           + $signed({{(EXW-1){1'b0}}, hi});
  end

  // round to nearest even at the position picked by the mode
  always_comb begin
    kd = m[PW-2 -: SIGW];
    gd = m[PW-2-SIGW];
    sd = (|m[PW-3-SIGW:0]) | xs;
    rd = {1'b0, kd} + (SIGW+1)'(gd & (sd | kd[0]));
    ks = m[PW-2 -: FRAC_S+1];
    gs = m[PW-3-FRAC_S];
    ss = (|m[PW-4-FRAC_S:0]) | xs;
    rs = {1'b0, ks} + (FRAC_S+2)'(gs & (ss | ks[0]));
    cy  = dbl ? rd[SIGW] : rs[FRAC_S+1];
    exr = ex + $signed({{(EXW-1){1'b0}}, cy});
    big  = (exr >= $signed({3'b000, emax}));
    tiny = (exr <= $signed(EXW'(0)));
  end

  // special-case selection and pack
  always_comb begin
    s_out = sgn;
    e_out = '0;
    f_out = '0;
    ovf   = 1'b0;
    inv   = 1'b0;
    if (na || nb || (ia && zb) || (za && ib)) begin
      s_out = 1'b0;
      e_out = emax;
      f_out = {1'b1, {(FRAC_D-1){1'b0}}};
      inv   = 1'b1;
    end else if (ia || ib) begin
      e_out = emax;
    end else if (za || zb) begin
      e_out = '0;
    end else if (big) begin
      e_out = emax;
      ovf   = 1'b1;
    end else if (tiny) begin
      e_out = '0;
    end else begin
      e_out = exr[EXP_D-1:0];
      f_out = dbl ? rd[FRAC_D-1:0] : {rs[FRAC_S-1:0], {ALIGN{1'b0}}};
    end
    r = dbl ? {s_out, e_out, f_out}
            : {{HW{1'b0}}, s_out, e_out[EXP_S-1:0], f_out[FRAC_D-1 -: FRAC_S]};
  end

  assign unused_bits = rd[FRAC_D] ^ rs[FRAC_S];
endmodule

// File: rtl/fpmul_dual.sv
module fpmul_dual
  import fpm_pkg::*;
#(
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_valid,
  input  logic          i_op,
  input  logic [DW-1:0] i_a,
  input  logic [DW-1:0] i_b,
  output logic          o_valid,
  output logic [DW-1:0] o_res,
  output logic [1:0]    o_ovf,
  output logic [1:0]    o_inv
);
  localparam int LAT = int'(IN_REG) + int'(OUT_REG);

  logic          rst_sn;
  logic          s_valid;
  fpm_op_e       s_op;
  logic [DW-1:0] s_a, s_b;
  logic [DW-1:0] r_lo, r_hi;
  logic          ovf_lo, ovf_hi, inv_lo, inv_hi;
  logic [DW-1:0] c_res;
  logic [1:0]    c_ovf, c_inv;
  logic          unused_hi;

  fpm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  generate
    if (IN_REG) begin : g_in
      logic          v_q;
      fpm_op_e       op_q, op_d;
      logic [DW-1:0] a_q, b_q, a_d, b_d;

      always_comb begin
        op_d = i_valid ? fpm_op_e'(i_op) : op_q;
        a_d  = i_valid ? i_a : a_q;
        b_d  = i_valid ? i_b : b_q;
      end

      always_ff @(posedge clk or negedge rst_sn) begin
        if (!rst_sn) v_q <= 1'b0;
        else         v_q <= i_valid;
      end

      always_ff @(posedge clk) begin
        op_q <= op_d;
        a_q  <= a_d;
        b_q  <= b_d;
      end

      assign s_valid = v_q;
      assign s_op    = op_q;
      assign s_a     = a_q;
      assign s_b     = b_q;
    end else begin : g_in_pass
      assign s_valid = i_valid;
      assign s_op    = fpm_op_e'(i_op);
      assign s_a     = i_a;
      assign s_b     = i_b;
    end
  endgenerate

  // lower lane serves both formats; upper lane is binary32 only
  fpm_lane u_lo (
    .dbl(s_op == FPM_ONE64), .a(s_a), .b(s_b),
    .r(r_lo), .ovf(ovf_lo), .inv(inv_lo)
  );

  fpm_lane u_hi (
    .dbl(1'b0),
    .a({{HW{1'b0}}, s_a[DW-1:HW]}), .b({{HW{1'b0}}, s_b[DW-1:HW]}),
    .r(r_hi), .ovf(ovf_hi), .inv(inv_hi)
  );

  always_comb begin
    if (s_op == FPM_ONE64) begin
      c_res = r_lo;
      c_ovf = {1'b0, ovf_lo};
      c_inv = {1'b0, inv_lo};
    end else begin
      c_res = {r_hi[HW-1:0], r_lo[HW-1:0]};
      c_ovf = {ovf_hi, ovf_lo};
      c_inv = {inv_hi, inv_lo};
    end
  end

  assign unused_hi = ^r_hi[DW-1:HW];

  generate
    if (OUT_REG) begin : g_out
      logic          v_q;
      logic [DW-1:0] res_q, res_d;
      logic [1:0]    ovf_q, ovf_d, inv_q, inv_d;

      always_comb begin
        res_d = s_valid ? c_res : res_q;
        ovf_d = s_valid ? c_ovf : ovf_q;
        inv_d = s_valid ? c_inv : inv_q;
      end

      always_ff @(posedge clk or negedge rst_sn) begin
        if (!rst_sn) v_q <= 1'b0;
        else         v_q <= s_valid;
      end

      always_ff @(posedge clk) begin
        res_q <= res_d;
        ovf_q <= ovf_d;
        inv_q <= inv_d;
      end

      assign o_valid = v_q;
      assign o_res   = res_q;
      assign o_ovf   = ovf_q;
      assign o_inv   = inv_q;
    end else begin : g_out_pass
      assign o_valid = s_valid;
      assign o_res   = c_res;
      assign o_ovf   = c_ovf;
      assign o_inv   = c_inv;
    end
  endgenerate
endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
  parameter int LAT = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        i_valid,
  input logic        o_valid,
  input logic [63:0] o_res,
  input logic [1:0]  o_ovf,
  input logic [1:0]  o_inv
);
  generate
    if (LAT > 0) begin : g_lat
      a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid == $past(i_valid, LAT));
    end
  endgenerate

  // R8: an invalid flag comes with the quiet NaN of its lane
  a_r8_inv_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_inv[1]) |-> (o_res[63:32] == 32'h7FC0_0000));
  a_r8_inv_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_inv[0]) |->
      ((o_res[31:0] == 32'h7FC0_0000) || (o_res == 64'h7FF8_0000_0000_0000)));

  // R7: an overflow flag comes with an infinity in its lane
  a_r7_ovf_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_ovf[1]) |-> (o_res[62:32] == 31'h7F80_0000));
  a_r7_ovf_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_ovf[0]) |->
      ((o_res[30:0] == 31'h7F80_0000) || (o_res[62:0] == 63'h7FF0_0000_0000_0000)));

  // R7 and R8: a lane never raises both flags
  a_r7_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> ((o_ovf & o_inv) == 2'b00));
endmodule

bind fpmul_dual fpm_checker #(.LAT(int'(IN_REG) + int'(OUT_REG))) u_chk (
  .clk(clk), .rst_n(rst_sn), .i_valid(i_valid), .o_valid(o_valid),
  .o_res(o_res), .o_ovf(o_ovf), .o_inv(o_inv)
);

// File: tb/tb_fpmul_dual.sv
module tb_fpmul_dual;
  localparam int LAT = 2;

  logic        clk;
  logic        rst_n;
  logic        i_valid;
  logic        i_op;
  logic [63:0] i_a, i_b;
  logic        o_valid;
  logic [63:0] o_res;
  logic [1:0]  o_ovf, o_inv;

  typedef struct {
    logic [63:0] res;
    logic [1:0]  ovf;
    logic [1:0]  inv;
    string       tag;
    int          cyc;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  bit    done = 0;

  logic [31:0] sa_t[15], sb_t[15], sr_t[15];
  logic        so_t[15], si_t[15];
  string       st_t[15];

  fpmul_dual dut (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_op(i_op),
    .i_a(i_a), .i_b(i_b), .o_valid(o_valid), .o_res(o_res),
    .o_ovf(o_ovf), .o_inv(o_inv)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic send(input logic op, input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] er, input logic [1:0] eo,
                      input logic [1:0] ei, input string tag);
    item_t it;
    @(negedge clk);
    i_valid = 1'b1;
    i_op = op;
    i_a = a;
    i_b = b;
    it.res = er; it.ovf = eo; it.inv = ei; it.tag = tag; it.cyc = cyc;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      i_valid = 1'b0;
      i_a = 64'hDEAD_BEEF_0BAD_F00D;
    end
  endtask

  // monitor: scoreboard compare
  always @(posedge clk) begin
    #2;
    if (rst_n && o_valid) begin
      item_t it;
      checks++;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected result res=%h exp=none", o_res);
      end else begin
        it = sb.pop_front();
        if (o_res !== it.res || o_ovf !== it.ovf || o_inv !== it.inv) begin
          failures++;
          $display("FAIL %s res=%h exp=%h ovf=%b exp=%b inv=%b exp=%b",
                   it.tag, o_res, it.res, o_ovf, it.ovf, o_inv, it.inv);
        end
        checks++;
        if (cyc - it.cyc != LAT) begin
          failures++;
          $display("FAIL R2 latency=%0d exp=%0d", cyc - it.cyc, LAT);
        end
      end
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired pending=%0d exp=0", sb.size());
      summary();
      $finish;
    end
  end

  task automatic set_s(input int k, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] r, input logic o, input logic v,
                       input string t);
    sa_t[k] = a; sb_t[k] = b; sr_t[k] = r; so_t[k] = o; si_t[k] = v; st_t[k] = t;
  endtask

  initial begin
    set_s(0,  32'h3FC00000, 32'h40000000, 32'h40400000, 0, 0, "R4");
    set_s(1,  32'hBFC00000, 32'h3FC00000, 32'hC0100000, 0, 0, "R3");
    set_s(2,  32'h3F800001, 32'h3FC00000, 32'h3FC00002, 0, 0, "R5");
    set_s(3,  32'h3F800003, 32'h3FC00000, 32'h3FC00004, 0, 0, "R5");
    set_s(4,  32'h3FFFFFFF, 32'h3F800001, 32'h40000000, 0, 0, "R5");
    set_s(5,  32'h7F000000, 32'h40000000, 32'h7F800000, 1, 0, "R7");
    set_s(6,  32'hFF000000, 32'h40000000, 32'hFF800000, 1, 0, "R7");
    set_s(7,  32'h00800000, 32'h3F000000, 32'h00000000, 0, 0, "R6");
    set_s(8,  32'h80800000, 32'h3F000000, 32'h80000000, 0, 0, "R6");
    set_s(9,  32'h80000000, 32'h3F800000, 32'h80000000, 0, 0, "R3");
    set_s(10, 32'h00000001, 32'h3F800000, 32'h00000000, 0, 0, "R6");
    set_s(11, 32'h7FC00001, 32'h3F800000, 32'h7FC00000, 0, 1, "R8");
    set_s(12, 32'h00000000, 32'h7F800000, 32'h7FC00000, 0, 1, "R8");
    set_s(13, 32'h7F800000, 32'hC0000000, 32'hFF800000, 0, 0, "R10");
    set_s(14, 32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 0, 0, "R4");

    rst_n = 1'b0;
    i_valid = 1'b0;
    i_op = 1'b0;
    i_a = '0;
    i_b = '0;
    repeat (5) @(posedge clk);
    #2;
    checks++;
    if (o_valid !== 1'b0) begin
      failures++;
      $display("FAIL R2 reset o_valid=%b exp=0", o_valid);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R9: every binary32 case in both halves, each time with a new partner
    for (int i = 0; i < 15; i++) begin
      int j;
      j = (i * 4 + 7) % 15;
      send(1'b0, {sa_t[j], sa_t[i]}, {sb_t[j], sb_t[i]}, {sr_t[j], sr_t[i]},
           {so_t[j], so_t[i]}, {si_t[j], si_t[i]},
           $sformatf("R9+%s/%s", st_t[j], st_t[i]));
    end
    idle(3);

    // R1: binary64 hand cases
    send(1'b1, 64'h3FF8000000000000, 64'h4000000000000000, 64'h4008000000000000,
         2'b00, 2'b00, "R1");
    send(1'b1, 64'h7FF0000000000000, 64'h0000000000000000, 64'h7FF8000000000000,
         2'b00, 2'b01, "R8");
    send(1'b1, 64'h7FE0000000000000, 64'h4000000000000000, 64'h7FF0000000000000,
         2'b01, 2'b00, "R7");
    send(1'b1, 64'h8000000000000000, 64'h3FF0000000000000, 64'h8000000000000000,
         2'b00, 2'b00, "R3");
    send(1'b1, 64'h0010000000000000, 64'h3FE0000000000000, 64'h0000000000000000,
         2'b00, 2'b00, "R6");
    idle(2);

    // R1/R5: binary64 random normals against the real product, mixed with gaps
    for (int n = 0; n < 120; n++) begin
      logic [63:0] a, b;
      real p;
      a = {1'(($urandom) & 1), 11'(823 + ($urandom % 400)), $urandom, 20'($urandom)};
      b = {1'(($urandom) & 1), 11'(823 + ($urandom % 400)), $urandom, 20'($urandom)};
      p = $bitstoreal(a) * $bitstoreal(b);
      send(1'b1, a, b, $realtobits(p), 2'b00, 2'b00, "R1+R5");
      if (n % 17 == 0) idle(1);
      if (n % 29 == 0) begin
        int j;
        j = n % 15;
        send(1'b0, {sa_t[j], sa_t[14 - j]}, {sb_t[j], sb_t[14 - j]},
             {sr_t[j], sr_t[14 - j]}, {so_t[j], so_t[14 - j]},
             {si_t[j], si_t[14 - j]}, "R1+R9 mode switch");
      end
    end
    idle(6);

    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R2 missing results=%0d exp=0", sb.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule